// File: doc/BRIEF.md
# Byte-Wide SPI Slave with Completion and Write-Collision Flags

This block is a slave-only SPI port for a processor subsystem. An external master supplies the serial clock, the data input and an active-low select. The block shifts one byte in from the master and, in the same transfer, shifts one byte out to the master. Transfers use mode 0: the clock idles low, data is sampled on the rising edge and changes on the falling edge, and the most significant bit goes first. All three serial inputs pass through two-flop synchronizers into the system clock, and the clock edges are detected there. The master must therefore hold each clock phase for several system clock cycles.

The processor reaches the block through a small register bus with two locations: a status register and a data register. A write to the data register loads the next byte to send. A read of the data register returns the last byte received. If no byte has been loaded since the last transfer, the next transfer sends back the byte just received, so the master sees its own previous byte again.

The status register has two flags. One flag marks the end of each byte. The other flag records a data-register write that arrived while a byte was shifting; that write is dropped. Both flags clear only through a two-step sequence: a status read, followed directly by a data read.

Top module: `spi_slave_flags`

## Requirements
- R1: With select low, the block samples `mosi_i` on each rising edge of `sck_i` (clock idle low), most significant bit first. After eight rising edges, a data read (`bus_addr_i`=1, `bus_we_i`=0) returns the assembled byte on `bus_rdata_o`.
- R2: The byte loaded by a data write made while no byte is shifting goes out on `miso_o`, most significant bit first. The first bit is present once select goes low, and each later bit follows a falling edge of `sck_i`.
- R3: If no data write was accepted since the previous transfer, the next transfer sends out the byte received in the previous transfer.
- R4: When the eighth rising edge of a byte is seen, the completion flag is set. It reads as bit 7 of the status register (`bus_addr_i`=0).
- R5: A data write made while a byte is shifting (one to seven bits received) sets the collision flag, which reads as status bit 6. The written value is discarded, and the byte in flight still goes out unchanged.
- R6: A status read followed by a data read as the next bus access clears both flags. After the byte is complete, the status then reads 0x00.
- R7: The clear sequence is broken if the second access is a data write, or if any other access (such as a status write) comes between the two reads. The collision flag then stays set.
- R8: If the clear sequence runs while a byte is shifting, the collision flag clears and the completion flag stays 0 until that byte's eighth rising edge, when it is set.
- R9: While `ss_ni` is high the slave is deselected: `miso_oe_o` is 0, `miso_o` is 0, and toggling `sck_i` neither sets the completion flag nor changes the received byte.
- R10: Status bits 5 to 0 always read 0, and writes to the status register have no effect on the flags.
- R11: After reset both flags are 0, the received byte reads 0x00 and the slave is deselected (`miso_oe_o`=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Register access strobe, one access per cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 1 | 0 = status register, 1 = data register |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the addressed register (combinational) |
| sck_i | input | 1 | Serial clock from the master |
| mosi_i | input | 1 | Serial data from the master |
| ss_ni | input | 1 | Slave select, active low |
| miso_o | output | 1 | Serial data to the master |
| miso_oe_o | output | 1 | Output enable for the MISO pad driver; 0 releases the line |

## Verification
The bench first runs a table of transfers that alternate between loaded bytes and echoed bytes. A design that loses the received byte from the shift register would send stale data where an echo is expected. It then writes the data register in the middle of a byte and checks three things: the collision flag is set, no completion is shown yet, and the master still gets the original byte; a design that honoured the write would corrupt that byte. The clear sequence is broken on purpose, with a data write as the second step and with a status write between the two reads, to catch a design that clears on any data access or keeps its armed state across unrelated accesses. A clear made during a byte must leave the completion flag low and then let it rise at the end of the byte. Clocking the bus while the slave is deselected must leave the flags and the received byte unchanged.

// File: rtl/spi_flags_pkg.sv
package spi_flags_pkg;
  typedef enum logic {
    ADDR_STAT = 1'b0,
    ADDR_DATA = 1'b1
  } reg_addr_e;

  localparam int unsigned DONE_BIT = 7;
  localparam int unsigned COLL_BIT = 6;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int unsigned WIDTH   = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q[i] <= RST_VAL[i];
        sync_q[i] <= RST_VAL[i];
      end else begin
        meta_q[i] <= d_i[i];
        sync_q[i] <= meta_q[i];
      end
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CNT_W = $clog2(DATA_W),
  localparam int unsigned MSB   = DATA_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              mosi_i,
  input  logic              ss_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_o,
  output logic              miso_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic              sck_d_q;
  logic              rise, fall;
  logic [DATA_W-1:0] sr_q, shifted;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] rx_q;
  logic              miso_q;

  assign rise    = sck_i & ~sck_d_q & ~ss_i;
  assign fall    = ~sck_i & sck_d_q & ~ss_i;
  assign shifted = {sr_q[MSB-1:0], mosi_i};
  assign done_o  = rise && (cnt_q == LAST);
  // edge cycles count as busy so a load never races a shift
  assign busy_o  = ~ss_i & ((cnt_q != '0) | rise | fall);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_d_q <= 1'b0;
      sr_q    <= '0;
      cnt_q   <= '0;
      rx_q    <= '0;
      miso_q  <= 1'b0;
    end else begin
      sck_d_q <= sck_i;
      if (ss_i) begin
        cnt_q <= '0;
        if (load_i) begin
          sr_q   <= load_data_i;
          miso_q <= load_data_i[MSB];
        end else begin
          miso_q <= sr_q[MSB];
        end
      end else if (rise) begin
        sr_q  <= shifted;
        cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        if (cnt_q == LAST) rx_q <= shifted;
      end else if (fall) begin
        miso_q <= sr_q[MSB];
      end else if (load_i) begin
        sr_q   <= load_data_i;
        miso_q <= load_data_i[MSB];
      end
    end
  end

  assign rx_o   = rx_q;
  assign miso_o = miso_q;

  // R9: deselect aborts any partial byte
  p_idle_cnt_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ss_i |=> (cnt_q == '0));
  // R4: completion strobe lasts one cycle
  p_done_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R1: received byte changes only at byte end
  p_rx_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |=> $stable(rx_q));
endmodule

// File: rtl/spi_regs.sv
module spi_regs
  import spi_flags_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] rx_i,
  output logic              load_o,
  output logic [DATA_W-1:0] load_data_o
);
  logic done_q, coll_q, armed_q;
  logic rd_stat, rd_data, wr_data, coll, clr;
  logic [DATA_W-1:0] status;

  assign rd_stat = sel_i & ~we_i & (addr_i == ADDR_STAT);
  assign rd_data = sel_i & ~we_i & (addr_i == ADDR_DATA);
  assign wr_data = sel_i &  we_i & (addr_i == ADDR_DATA);
  assign coll    = wr_data & busy_i;
  assign clr     = rd_data & armed_q;

  assign load_o      = wr_data & ~busy_i;
  assign load_data_o = wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q  <= 1'b0;
      coll_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (sel_i) armed_q <= rd_stat;
      if (done_i)   done_q <= 1'b1;
      else if (clr) done_q <= 1'b0;
      if (coll)     coll_q <= 1'b1;
      else if (clr) coll_q <= 1'b0;
    end
  end

  always_comb begin
    status           = '0;
    status[DONE_BIT] = done_q;
    status[COLL_BIT] = coll_q;
  end

  assign rdata_o = (addr_i == ADDR_DATA) ? rx_i : status;

  // R4: completion flag rises only on a byte end
  p_done_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> $past(done_i));
  // R5: collision flag rises only on a write during a byte
  p_coll_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(coll_q) |-> $past(wr_data && busy_i));
  // R6, R7: flags fall only after status read then data read
  p_coll_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(coll_q) |-> $past(rd_data && armed_q));
  p_done_clr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(done_q) |-> $past(rd_data && armed_q));
  // R10: unused status bits stay zero
  p_stat_pad_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(status) <= 2);
endmodule

// File: rtl/spi_slave_flags.sv
module spi_slave_flags #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic              bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic              sck_i,
  input  logic              mosi_i,
  input  logic              ss_ni,
  output logic              miso_o,
  output logic              miso_oe_o
);
  logic [2:0]        pins_s;
  logic              sck_s, mosi_s, ss_s;
  logic              busy, done, load, miso_raw;
  logic [DATA_W-1:0] rx, load_data;

  // select resets high so the slave starts deselected
  spi_sync #(.WIDTH(3), .RST_VAL(3'b100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ss_ni, mosi_i, sck_i}),
    .q_o   (pins_s)
  );
  assign {ss_s, mosi_s, sck_s} = pins_s;

  spi_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sck_i      (sck_s),
    .mosi_i     (mosi_s),
    .ss_i       (ss_s),
    .load_i     (load),
    .load_data_i(load_data),
    .busy_o     (busy),
    .done_o     (done),
    .rx_o       (rx),
    .miso_o     (miso_raw)
  );

  spi_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_i      (bus_sel_i),
    .we_i       (bus_we_i),
    .addr_i     (bus_addr_i),
    .wdata_i    (bus_wdata_i),
    .rdata_o    (bus_rdata_o),
    .busy_i     (busy),
    .done_i     (done),
    .rx_i       (rx),
    .load_o     (load),
    .load_data_o(load_data)
  );

  assign miso_oe_o = ~ss_s;
  assign miso_o    = miso_raw & ~ss_s;

  // R9: a deselected slave never signals a byte end
  p_no_done_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ss_s |-> !done);
  // R5: a write during a byte never loads the shifter
  p_no_load_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !load);
endmodule

// File: tb/tb_spi_slave_flags.sv
module tb_spi_slave_flags;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;

  logic       clk = 1'b0, rst_ni = 1'b0;
  logic       sel = 1'b0, we = 1'b0, addr = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic       sck = 1'b0, mosi = 1'b0, ss_n = 1'b1;
  logic       miso, miso_oe;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [7:0] cap, rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_slave_flags dut (
    .clk_i(clk), .rst_ni(rst_ni), .bus_sel_i(sel), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .sck_i(sck), .mosi_i(mosi), .ss_ni(ss_n),
    .miso_o(miso), .miso_oe_o(miso_oe)
  );

  // {preload valid, preload byte, master byte, expected slave byte}
  localparam logic [24:0] VEC [5] = '{
    {1'b1, 8'hA5, 8'h3C, 8'hA5},
    {1'b0, 8'h00, 8'h96, 8'h3C},
    {1'b1, 8'h00, 8'hFF, 8'h00},
    {1'b0, 8'h00, 8'h01, 8'hFF},
    {1'b1, 8'h80, 8'h7E, 8'h80}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_rd(input logic a, output logic [7:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b0; addr = a;
    #2 d = rdata;
    @(negedge clk);
    sel = 1'b0;
  endtask

  task automatic bus_wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic ss_on();
    ss_n = 1'b0; cap = '0;
    wait_clk(HALF);
  endtask

  task automatic ss_off();
    wait_clk(HALF);
    ss_n = 1'b1;
    wait_clk(HALF);
  endtask

  task automatic spi_bits(input logic [7:0] tx, input int hi, input int lo);
    for (int i = hi; i >= lo; i--) begin
      mosi = tx[i];
      wait_clk(HALF);
      cap[i] = miso;
      sck = 1'b1;
      wait_clk(HALF);
      sck = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    wait_clk(3);
    // R11 reset state
    chk("R11 status", rdata, 8'h00);
    chk("R11 oe", {7'b0, miso_oe}, 8'h00);
    rst_ni = 1'b1;
    wait_clk(3);
    bus_rd(1'b1, rd); chk("R11 rx", rd, 8'h00);

    // R1 R2 R3 R4 R6 table
    foreach (VEC[k]) begin
      if (VEC[k][24]) bus_wr(1'b1, VEC[k][23:16]);
      ss_on();
      chk("R9 oe selected", {7'b0, miso_oe}, 8'h01);
      spi_bits(VEC[k][15:8], 7, 0);
      ss_off();
      chk(VEC[k][24] ? "R2 miso" : "R3 echo", cap, VEC[k][7:0]);
      bus_rd(1'b0, rd); chk("R4 done flag", rd, 8'h80);
      bus_rd(1'b1, rd); chk("R1 rx byte", rd, VEC[k][15:8]);
      bus_rd(1'b0, rd); chk("R6 cleared", rd, 8'h00);
    end

    // R9 deselected
    chk("R9 oe idle", {6'b0, miso_oe, miso}, 8'h00);
    mosi = 1'b1;
    for (int i = 0; i < 8; i++) begin
      sck = 1'b1; wait_clk(HALF); sck = 1'b0; wait_clk(HALF);
    end
    bus_rd(1'b0, rd); chk("R9 no flag", rd, 8'h00);
    bus_rd(1'b1, rd); chk("R9 rx kept", rd, 8'h7E);

    // R5 collision mid-byte
    bus_wr(1'b1, 8'h11);
    ss_on();
    spi_bits(8'hC3, 7, 4);
    bus_wr(1'b1, 8'h55);
    bus_rd(1'b0, rd); chk("R5 coll set", rd, 8'h40);
    spi_bits(8'hC3, 3, 0);
    ss_off();
    chk("R5 byte intact", cap, 8'h11);
    bus_rd(1'b0, rd); chk("R5 both flags", rd, 8'hC0);

    // R7 write as second step
    bus_wr(1'b1, 8'h22);
    bus_rd(1'b0, rd); chk("R7 kept after write", rd, 8'hC0);
    // R7 status write between the reads, R10 write ignored
    bus_wr(1'b0, 8'hFF);
    bus_rd(1'b1, rd); chk("R7 rx", rd, 8'hC3);
    bus_rd(1'b0, rd); chk("R10 R7 kept", rd, 8'hC0);
    bus_rd(1'b1, rd);
    bus_rd(1'b0, rd); chk("R6 cleared", rd, 8'h00);

    // R8 clear during a byte
    ss_on();
    spi_bits(8'h5A, 7, 5);
    bus_wr(1'b1, 8'h99);
    bus_rd(1'b0, rd); chk("R8 coll mid", rd, 8'h40);
    bus_rd(1'b1, rd);
    bus_rd(1'b0, rd); chk("R8 cleared mid", rd, 8'h00);
    spi_bits(8'h5A, 4, 0);
    ss_off();
    chk("R8 byte sent", cap, 8'h22);
    bus_rd(1'b0, rd); chk("R8 done at end", rd, 8'h80);
    bus_rd(1'b1, rd); chk("R8 rx", rd, 8'h5A);

    finished = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule